// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservations that load-linked accesses place on cache lines and decides, when a store-conditional completes, whether it may take effect. Each completion event names a line address, an access kind and the identity (version) of the requester. A separate strobe reports that the cache lost coherence permission for a line.

For every completion the block answers one cycle later with a success bit and a write-enable. The write-enable tells the data path whether the line's data may be updated: it is low for loads and for a failed store-conditional. One reservation register is kept per requester version. A line holds at most one reservation at a time. The cache array and the coherence protocol sit outside the block.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no reservation is held and all three response outputs are 0. One cycle after a completion is accepted (`cmp_valid` high), `rsp_valid` is 1 and carries that completion's result. In a cycle after one with no completion, all response outputs are 0.
- R2: A load-linked (kind code 2'b01) to a present line sets the requester's reservation to that line, replacing any line that version held before. It answers ok=1, wr_en=0.
- R3: A store-conditional (kind code 2'b10) to a present line answers ok=1, wr_en=1 only when the requester's own reservation is on that line. Otherwise it answers ok=0, wr_en=0.
- R4: A store-conditional to a present line removes any reservation on that line, whether it succeeds or fails. A repeated store-conditional to the same line therefore fails.
- R5: An ordinary write (kind code 2'b11) to a present line answers ok=1, wr_en=1. It removes the reservation on that line only if the writer's own version holds it. A reservation held by another version survives the write.
- R6: A plain read (kind code 2'b00) answers ok=1, wr_en=0 and changes no reservation.
- R7: A completion whose line is not present (`cmp_present` low) answers ok=1 and changes no reservation. Its wr_en is 1 for kinds 2'b10 and 2'b11 and 0 otherwise.
- R8: An invalidate (`inv_valid`) removes every reservation on `inv_line`. It takes effect before a completion in the same cycle, so a store-conditional to that line in that cycle fails, and a load-linked to that line in that cycle still sets its reservation.
- R9: A load-linked to a line reserved by another version moves the reservation to the new requester, and the earlier holder's later store-conditional to that line fails.
- R10: A reservation on one line is untouched by a store-conditional, write or invalidate aimed at a different line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | A completion event is presented this cycle |
| cmp_kind | input | 2 | Access kind: 00 read, 01 load-linked, 10 store-conditional, 11 write |
| cmp_ver | input | VER_W | Requester version of the completion |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_present | input | 1 | The line is present in the cache |
| inv_valid | input | 1 | Coherence permission lost for `inv_line` |
| inv_line | input | LINE_W | Line address being invalidated |
| rsp_valid | output | 1 | Result of the previous cycle's completion is valid |
| rsp_ok | output | 1 | Success bit (1 success, 0 failed store-conditional) |
| rsp_wr_en | output | 1 | Line data may be updated |

## Verification
The assertions assume that `cmp_ver` stays below the number of versions and that the inputs keep known values whenever reset is released. They assume nothing about address reuse or about how completions and invalidates interleave. The stimulus draws versions only from the configured range and holds every input at a defined level during reset. Directed sequences cover each same-cycle interplay of an invalidate with a load-linked or store-conditional. A random phase then squeezes traffic onto four lines, so that reservations collide, migrate and are cleared often.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        KIND_READ      = 2'b00,
        KIND_LOADLINK  = 2'b01,
        KIND_STORECOND = 2'b10,
        KIND_WRITE     = 2'b11
    } cmp_kind_e;

    typedef struct packed {
        logic valid;
        logic ok;
        logic wr_en;
    } rsp_t;

endpackage

// File: rtl/rsv_slot.sv
module rsv_slot #(
    parameter int LINE_W  = 26,
    parameter int VER_W   = 2,
    parameter int SLOT_ID = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_valid,
    input  logic                  cmp_present,
    input  rsv_pkg::cmp_kind_e    cmp_kind,
    input  logic [VER_W-1:0]      cmp_ver,
    input  logic [LINE_W-1:0]     cmp_line,
    input  logic                  inv_valid,
    input  logic [LINE_W-1:0]     inv_line,
    output logic                  held,
    output logic [LINE_W-1:0]     held_line,
    output logic                  live_hit
);
    import rsv_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
    } slot_t;

    slot_t s_d, s_q;
    logic  mine;
    logic  inv_kill;
    logic  alive;
    logic  ll_mine;

    always_comb begin
        mine     = (cmp_ver == VER_W'(SLOT_ID));
        inv_kill = inv_valid && s_q.valid && (s_q.line == inv_line);
        alive    = s_q.valid && !inv_kill;
        live_hit = alive && (s_q.line == cmp_line);
        ll_mine  = cmp_valid && cmp_present && (cmp_kind == KIND_LOADLINK) && mine;
        s_d       = s_q;
        s_d.valid = alive;
        if (cmp_valid && cmp_present) begin
            case (cmp_kind)
                KIND_LOADLINK: begin
                    if (mine) begin
                        s_d.valid = 1'b1;
                        s_d.line  = cmp_line;
                    end else if (live_hit) begin
                        s_d.valid = 1'b0;
                    end
                end
                KIND_STORECOND: begin
                    if (live_hit) s_d.valid = 1'b0;
                end
                KIND_WRITE: begin
                    if (mine && live_hit) s_d.valid = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held      = s_q.valid;
    assign held_line = s_q.line;

    a_r2_ll_claims: assert property (@(posedge clk) disable iff (!rst_n)
        ll_mine |=> (held && held_line == $past(cmp_line)));

    a_r4_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_present && cmp_kind == KIND_STORECOND && live_hit) |=> !held);

    a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_kill && !ll_mine) |=> !held);

    a_r7_absent_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_present && !inv_valid) |=> ($stable(held) && $stable(held_line)));

    a_r5_foreign_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_present && cmp_kind == KIND_WRITE && !mine && !inv_valid)
        |=> $stable(held));

endmodule

// File: rtl/rsv_judge.sv
module rsv_judge #(
    parameter int NVER  = 4,
    parameter int VER_W = 2
) (
    input  logic                cmp_valid,
    input  logic                cmp_present,
    input  rsv_pkg::cmp_kind_e  cmp_kind,
    input  logic [VER_W-1:0]    cmp_ver,
    input  logic [NVER-1:0]     hit_vec,
    output rsv_pkg::rsp_t       rsp
);
    import rsv_pkg::*;

    logic own_hit;

    always_comb begin
        own_hit   = hit_vec[cmp_ver];
        rsp.valid = cmp_valid;
        rsp.ok    = cmp_valid;
        rsp.wr_en = 1'b0;
        if (cmp_valid) begin
            if (!cmp_present) begin
                rsp.wr_en = (cmp_kind == KIND_STORECOND) || (cmp_kind == KIND_WRITE);
            end else begin
                case (cmp_kind)
                    KIND_STORECOND: begin
                        rsp.ok    = own_hit;
                        rsp.wr_en = own_hit;
                    end
                    KIND_WRITE: rsp.wr_en = 1'b1;
                    default:    rsp.wr_en = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
    parameter int NVER   = 4,
    parameter int LINE_W = 26,
    parameter int VER_W  = (NVER > 1) ? $clog2(NVER) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_kind,
    input  logic [VER_W-1:0]  cmp_ver,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic              cmp_present,
    input  logic              inv_valid,
    input  logic [LINE_W-1:0] inv_line,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_wr_en
);
    import rsv_pkg::*;

    cmp_kind_e         kind;
    logic [NVER-1:0]   held;
    logic [NVER-1:0]   hit_vec;
    logic [LINE_W-1:0] held_line [NVER];
    rsp_t              rsp_d, rsp_q;

    assign kind = cmp_kind_e'(cmp_kind);

    for (genvar g = 0; g < NVER; g++) begin : g_slot
        rsv_slot #(
            .LINE_W  (LINE_W),
            .VER_W   (VER_W),
            .SLOT_ID (g)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmp_valid   (cmp_valid),
            .cmp_present (cmp_present),
            .cmp_kind    (kind),
            .cmp_ver     (cmp_ver),
            .cmp_line    (cmp_line),
            .inv_valid   (inv_valid),
            .inv_line    (inv_line),
            .held        (held[g]),
            .held_line   (held_line[g]),
            .live_hit    (hit_vec[g])
        );
    end

    rsv_judge #(
        .NVER  (NVER),
        .VER_W (VER_W)
    ) u_judge (
        .cmp_valid   (cmp_valid),
        .cmp_present (cmp_present),
        .cmp_kind    (kind),
        .cmp_ver     (cmp_ver),
        .hit_vec     (hit_vec),
        .rsp         (rsp_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_ok    = rsp_q.ok;
    assign rsp_wr_en = rsp_q.wr_en;

    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> rsp_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> (!rsp_valid && !rsp_ok && !rsp_wr_en));

    a_r3_fail_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> !rsp_wr_en);

    a_r6_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && kind == KIND_READ) |=> (rsp_ok && !rsp_wr_en));

    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NVER; i++) begin
                for (int j = i + 1; j < NVER; j++) begin
                    a_r9_one_holder: assert (!(held[i] && held[j] && held_line[i] == held_line[j]))
                        else $error("line reserved by two versions");
                end
            end
        end
    end

endmodule

// File: tb/sim_rsv_monitor.sv
module sim_rsv_monitor;
    localparam int NVER   = 4;
    localparam int LINE_W = 26;
    localparam int VER_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmp_valid;
    logic [1:0]        cmp_kind;
    logic [VER_W-1:0]  cmp_ver;
    logic [LINE_W-1:0] cmp_line;
    logic              cmp_present;
    logic              inv_valid;
    logic [LINE_W-1:0] inv_line;
    logic              rsp_valid, rsp_ok, rsp_wr_en;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;
    int owner [int];

    always #5 clk = ~clk;

    rsv_monitor #(.NVER(NVER), .LINE_W(LINE_W), .VER_W(VER_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .cmp_ver(cmp_ver), .cmp_line(cmp_line), .cmp_present(cmp_present),
        .inv_valid(inv_valid), .inv_line(inv_line),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_wr_en(rsp_wr_en));

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic check(string tag, bit ev, bit eo, bit ew);
        compared++;
        if (rsp_valid !== ev || rsp_ok !== eo || rsp_wr_en !== ew) begin
            mismatched++;
            $display("FAIL %s: valid/ok/wr_en got %b%b%b expected %b%b%b",
                     tag, rsp_valid, rsp_ok, rsp_wr_en, ev, eo, ew);
        end
    endtask

    // Drive one cycle at a falling edge, predict, compare at the next falling edge.
    task automatic step(string tag, bit cv, bit [1:0] k, int v, int a,
                        bit pres, bit iv, int ia);
        bit eo, ew;
        cmp_valid   = cv;
        cmp_kind    = k;
        cmp_ver     = VER_W'(v);
        cmp_line    = LINE_W'(a);
        cmp_present = pres;
        inv_valid   = iv;
        inv_line    = LINE_W'(ia);
        if (iv && owner.exists(ia)) owner.delete(ia);
        eo = cv;
        ew = 1'b0;
        if (cv) begin
            if (!pres) begin
                ew = k[1];
            end else if (k == 2'b01) begin
                int drop [$];
                foreach (owner[key]) if (owner[key] == v) drop.push_back(key);
                foreach (drop[n]) owner.delete(drop[n]);
                owner[a] = v;
            end else if (k == 2'b10) begin
                eo = owner.exists(a) && owner[a] == v;
                ew = eo;
                if (owner.exists(a)) owner.delete(a);
            end else if (k == 2'b11) begin
                ew = 1'b1;
                if (owner.exists(a) && owner[a] == v) owner.delete(a);
            end
        end
        @(negedge clk);
        check(tag, cv, eo, ew);
    endtask

    // kind codes
    localparam bit [1:0] RD = 2'b00, LL = 2'b01, SC = 2'b10, WR = 2'b11;

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: run did not end, got hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 0; cmp_valid = 0; cmp_kind = 0; cmp_ver = 0; cmp_line = 0;
        cmp_present = 0; inv_valid = 0; inv_line = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 reset outputs", 0, 0, 0);
        for (int v = 0; v < NVER; v++) step("R1 no reservation after reset", 1, SC, v, 'h10, 1, 0, 0);
        step("R1 idle", 0, RD, 0, 0, 1, 0, 0);
        // R2 / R3 / R4
        step("R2 ll", 1, LL, 1, 'hA0, 1, 0, 0);
        step("R3 sc own", 1, SC, 1, 'hA0, 1, 0, 0);
        step("R4 sc repeat", 1, SC, 1, 'hA0, 1, 0, 0);
        step("R2 ll", 1, LL, 2, 'hB0, 1, 0, 0);
        step("R3 sc other version", 1, SC, 3, 'hB0, 1, 0, 0);
        step("R4 failed sc cleared", 1, SC, 2, 'hB0, 1, 0, 0);
        step("R2 ll first", 1, LL, 0, 'hC0, 1, 0, 0);
        step("R2 ll replaces", 1, LL, 0, 'hD0, 1, 0, 0);
        step("R2 old line gone", 1, SC, 0, 'hC0, 1, 0, 0);
        step("R2 new line held", 1, SC, 0, 'hD0, 1, 0, 0);
        // R5
        step("R5 ll", 1, LL, 1, 'hE0, 1, 0, 0);
        step("R5 foreign write", 1, WR, 2, 'hE0, 1, 0, 0);
        step("R5 survives", 1, SC, 1, 'hE0, 1, 0, 0);
        step("R5 ll", 1, LL, 1, 'hE0, 1, 0, 0);
        step("R5 own write", 1, WR, 1, 'hE0, 1, 0, 0);
        step("R5 cleared", 1, SC, 1, 'hE0, 1, 0, 0);
        // R6
        step("R6 ll", 1, LL, 3, 'hF0, 1, 0, 0);
        step("R6 read own", 1, RD, 3, 'hF0, 1, 0, 0);
        step("R6 read other", 1, RD, 0, 'hF0, 1, 0, 0);
        step("R6 kept", 1, SC, 3, 'hF0, 1, 0, 0);
        // R7
        step("R7 ll", 1, LL, 2, 'h100, 1, 0, 0);
        step("R7 absent sc", 1, SC, 2, 'h100, 0, 0, 0);
        step("R7 absent write", 1, WR, 2, 'h100, 0, 0, 0);
        step("R7 absent read", 1, RD, 2, 'h100, 0, 0, 0);
        step("R7 kept", 1, SC, 2, 'h100, 1, 0, 0);
        step("R7 absent ll", 1, LL, 0, 'h110, 0, 0, 0);
        step("R7 absent ll no effect", 1, SC, 0, 'h110, 1, 0, 0);
        // R8
        step("R8 ll", 1, LL, 1, 'h120, 1, 0, 0);
        step("R8 invalidate", 0, RD, 0, 0, 1, 1, 'h120);
        step("R8 gone", 1, SC, 1, 'h120, 1, 0, 0);
        step("R8 ll", 1, LL, 3, 'h130, 1, 0, 0);
        step("R8 inv with sc", 1, SC, 3, 'h130, 1, 1, 'h130);
        step("R8 inv with ll", 1, LL, 0, 'h140, 1, 1, 'h140);
        step("R8 ll after inv held", 1, SC, 0, 'h140, 1, 0, 0);
        // R9
        step("R9 ll v0", 1, LL, 0, 'h150, 1, 0, 0);
        step("R9 ll v1 steals", 1, LL, 1, 'h150, 1, 0, 0);
        step("R9 old holder fails", 1, SC, 0, 'h150, 1, 0, 0);
        step("R9 ll v0", 1, LL, 0, 'h160, 1, 0, 0);
        step("R9 ll v2 steals", 1, LL, 2, 'h160, 1, 0, 0);
        step("R9 new holder wins", 1, SC, 2, 'h160, 1, 0, 0);
        // R10
        step("R10 ll", 1, LL, 2, 'h170, 1, 0, 0);
        step("R10 sc other line", 1, SC, 2, 'h180, 1, 0, 0);
        step("R10 write other line", 1, WR, 2, 'h180, 1, 0, 0);
        step("R10 inv other line", 0, RD, 0, 0, 1, 1, 'h180);
        step("R10 kept", 1, SC, 2, 'h170, 1, 0, 0);
        // mixed traffic on four lines
        for (int n = 0; n < 400; n++) begin
            step("MIX R3 R4 R5 R8 R9", ($urandom % 5) != 0, 2'($urandom % 4),
                 int'($urandom % NVER), 'h200 + int'($urandom % 4),
                 ($urandom % 6) != 0, ($urandom % 6) == 0, 'h200 + int'($urandom % 4));
        end
        step("R1 idle end", 0, RD, 0, 0, 1, 0, 0);
        finish_run();
    end

endmodule